// File: doc/BRIEF.md
# Node Identifier Wake-Up Sequencer

This block keeps a network node's protocol core dormant until the host loads a usable node identifier. While the identifier register holds zero, the node must stay silent. It runs no microcode, passes no token and starts no reconfiguration. When the host writes a non-zero identifier, the core wakes. The sequencer then writes a fixed signature byte and the identifier into the first two locations of the packet buffer RAM, on two consecutive clocks. This gives software a way to check that the sequencing logic is alive.

After that self-test the node waits in a holding state. It joins the network only once the host sets the transmit-enable bit in the configuration register. Joining is reported by a join flag and by a sticky "own reconfiguration" flag. The setup register may be written at any time, including while the core sleeps, so software can program it before the identifier. Two kinds of reset return the sequencer to sleep: the hardware reset pin and a software reset bit in the configuration register. The sequencer then needs a fresh non-zero identifier write before it wakes again.

States: SLEEP, WR_SIG (signature write), WR_ID (identifier write), WAIT_TX (awake, waiting for transmit enable), JOINED. Transitions: SLEEP→WR_SIG on a non-zero identifier write; WR_SIG→WR_ID and WR_ID→WAIT_TX unconditionally; WAIT_TX→JOINED when transmit enable is set; JOINED→WAIT_TX when it is cleared; any state→WR_SIG on a non-zero identifier write; any state→SLEEP on a zero identifier write or while the software reset bit is set.

Top module: `nid_wake_seq`

## Requirements
- R1: After hardware reset, and while no non-zero identifier has been accepted, core_awake, join_net, busy, my_recon and ram_we are all 0; writing zero to the identifier register (host_addr 0) while asleep leaves it asleep.
- R2: A host write of a non-zero value to host_addr 0 makes core_awake 1 in the cycle after the write edge.
- R3: In the first cycle after that write, ram_we=1, ram_addr=0 and ram_wdata=D1h. In the second cycle, ram_we=1, ram_addr=1 and ram_wdata is the identifier. busy is 1 in exactly those two cycles.
- R4: After the self-test the node stays awake with join_net=0 until bit 5 of the configuration register (host_addr 2) is 1. join_net rises one cycle after the first edge on which the sequencer is waiting and sees that bit set.
- R5: my_recon becomes 1 on the edge where join_net rises. It stays 1 while the core is awake, and returns to 0 when the core goes to sleep.
- R6: Clearing configuration bit 5 while joined drops join_net one cycle after the register update, and the core stays awake.
- R7: Writes to the setup register (host_addr 1) are accepted in every state, including asleep, and show on setup_q the cycle after the write.
- R8: Writing zero to the identifier register while awake sends the core to sleep in the next cycle, dropping join_net and my_recon.
- R9: While configuration bit 7 is 1, the sequencer is held asleep, the identifier register is cleared and identifier writes are ignored. Setup and configuration writes still take effect. After bit 7 is cleared, the core stays asleep until a new non-zero identifier is written.
- R10: A non-zero identifier write while awake restarts the two-cycle self-test with the new identifier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 2 | Register select: 0 identifier, 1 setup, 2 configuration |
| host_wdata | input | 8 | Host write data |
| ram_we | output | 1 | Buffer RAM write enable |
| ram_addr | output | 11 | Buffer RAM address |
| ram_wdata | output | 8 | Buffer RAM write data |
| core_awake | output | 1 | Core is out of sleep |
| join_net | output | 1 | Node takes part in the network |
| busy | output | 1 | Self-test RAM writes in progress |
| my_recon | output | 1 | Sticky flag: this node caused a reconfiguration by joining |
| setup_q | output | 8 | Current setup register contents |

## Verification
Every result is registered once. Wake-up and the signature write appear one cycle after the identifier write edge, and the identifier write appears one cycle after that. The join flag needs two edges after a configuration write that sets transmit enable: one to load the register and one for the state change. The soft reset likewise acts one edge after the configuration bit is stored. The bench's reference model steps on the same rising edges as the design, and all outputs are compared at the following falling edge. Scenario checks sample the RAM model and flags at the falling edge that lies the stated number of cycles after each write.

// File: rtl/nws_pkg.sv
package nws_pkg;

    typedef enum logic [2:0] {
        ST_SLEEP,
        ST_WR_SIG,
        ST_WR_ID,
        ST_WAIT_TX,
        ST_JOINED
    } nws_state_e;

    localparam logic [1:0] REG_NODE_ID = 2'd0;
    localparam logic [1:0] REG_SETUP   = 2'd1;
    localparam logic [1:0] REG_CONFIG  = 2'd2;

endpackage

// File: rtl/nws_regs.sv
module nws_regs
    import nws_pkg::*;
#(
    parameter int DW       = 8,
    parameter int SRST_BIT = 7,
    parameter int TXEN_BIT = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_we,
    input  logic [1:0]    host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] nid_q,
    output logic [DW-1:0] setup_q,
    output logic [DW-1:0] cfg_q,
    output logic          nid_wr,
    output logic          nid_nz,
    output logic          srst_act,
    output logic          tx_en
);

    assign srst_act = cfg_q[SRST_BIT];
    assign tx_en    = cfg_q[TXEN_BIT];
    assign nid_wr   = host_we && (host_addr == REG_NODE_ID) && !srst_act;
    assign nid_nz   = |host_wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nid_q   <= '0;
            setup_q <= '0;
            cfg_q   <= '0;
        end else begin
            if (host_we && host_addr == REG_SETUP)
                setup_q <= host_wdata;
            if (host_we && host_addr == REG_CONFIG)
                cfg_q <= host_wdata;
            if (srst_act)
                nid_q <= '0;
            else if (nid_wr)
                nid_q <= host_wdata;
        end
    end

endmodule

// File: rtl/nws_fsm.sv
module nws_fsm
    import nws_pkg::*;
#(
    parameter int          AW  = 11,
    parameter int          DW  = 8,
    parameter logic [7:0]  SIG = 8'hD1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          srst_act,
    input  logic          nid_wr,
    input  logic          nid_nz,
    input  logic          tx_en,
    input  logic [DW-1:0] nid_q,
    output logic          ram_we,
    output logic [AW-1:0] ram_addr,
    output logic [DW-1:0] ram_wdata,
    output logic          core_awake,
    output logic          join_net,
    output logic          busy,
    output logic          my_recon
);

    nws_state_e state, nxt;

    always_comb begin
        nxt = state;
        if (srst_act)
            nxt = ST_SLEEP;
        else if (nid_wr)
            nxt = nid_nz ? ST_WR_SIG : ST_SLEEP;
        else begin
            unique case (state)
                ST_SLEEP:   nxt = ST_SLEEP;
                ST_WR_SIG:  nxt = ST_WR_ID;
                ST_WR_ID:   nxt = ST_WAIT_TX;
                ST_WAIT_TX: nxt = tx_en ? ST_JOINED : ST_WAIT_TX;
                ST_JOINED:  nxt = tx_en ? ST_JOINED : ST_WAIT_TX;
                default:    nxt = ST_SLEEP;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_SLEEP;
        else
            state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            my_recon <= 1'b0;
        else if (nxt == ST_SLEEP)
            my_recon <= 1'b0;
        else if (state == ST_WAIT_TX && nxt == ST_JOINED)
            my_recon <= 1'b1;
    end

    always_comb begin
        ram_we     = 1'b0;
        ram_addr   = '0;
        ram_wdata  = '0;
        core_awake = 1'b1;
        join_net   = 1'b0;
        busy       = 1'b0;
        unique case (state)
            ST_SLEEP: core_awake = 1'b0;
            ST_WR_SIG: begin
                ram_we    = 1'b1;
                ram_wdata = DW'(SIG);
                busy      = 1'b1;
            end
            ST_WR_ID: begin
                ram_we    = 1'b1;
                ram_addr  = AW'(1);
                ram_wdata = nid_q;
                busy      = 1'b1;
            end
            ST_WAIT_TX: ;
            ST_JOINED: join_net = 1'b1;
            default: core_awake = 1'b0;
        endcase
    end

endmodule

// File: rtl/nid_wake_seq.sv
module nid_wake_seq
    import nws_pkg::*;
#(
    parameter int         AW       = 11,
    parameter int         DW       = 8,
    parameter int         SRST_BIT = 7,
    parameter int         TXEN_BIT = 5,
    parameter logic [7:0] SIG      = 8'hD1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_we,
    input  logic [1:0]    host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic          ram_we,
    output logic [AW-1:0] ram_addr,
    output logic [DW-1:0] ram_wdata,
    output logic          core_awake,
    output logic          join_net,
    output logic          busy,
    output logic          my_recon,
    output logic [DW-1:0] setup_q
);

    logic [DW-1:0] nid_q;
    logic [DW-1:0] cfg_q;
    logic          nid_wr;
    logic          nid_nz;
    logic          srst_act;
    logic          tx_en;

    nws_regs #(
        .DW       (DW),
        .SRST_BIT (SRST_BIT),
        .TXEN_BIT (TXEN_BIT)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .nid_q      (nid_q),
        .setup_q    (setup_q),
        .cfg_q      (cfg_q),
        .nid_wr     (nid_wr),
        .nid_nz     (nid_nz),
        .srst_act   (srst_act),
        .tx_en      (tx_en)
    );

    nws_fsm #(
        .AW  (AW),
        .DW  (DW),
        .SIG (SIG)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .srst_act   (srst_act),
        .nid_wr     (nid_wr),
        .nid_nz     (nid_nz),
        .tx_en      (tx_en),
        .nid_q      (nid_q),
        .ram_we     (ram_we),
        .ram_addr   (ram_addr),
        .ram_wdata  (ram_wdata),
        .core_awake (core_awake),
        .join_net   (join_net),
        .busy       (busy),
        .my_recon   (my_recon)
    );

endmodule

// File: rtl/nid_wake_seq_chk.sv
module nid_wake_seq_chk #(
    parameter int         AW       = 11,
    parameter int         DW       = 8,
    parameter int         SRST_BIT = 7,
    parameter int         TXEN_BIT = 5,
    parameter logic [7:0] SIG      = 8'hD1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          host_we,
    input logic [1:0]    host_addr,
    input logic [DW-1:0] host_wdata,
    input logic [DW-1:0] cfg_q,
    input logic          ram_we,
    input logic [AW-1:0] ram_addr,
    input logic [DW-1:0] ram_wdata,
    input logic          core_awake,
    input logic          join_net,
    input logic          busy,
    input logic          my_recon
);

    a_r1_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !core_awake |-> (!ram_we && !join_net && !busy && !my_recon));

    a_r2_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_addr == 2'd0 && host_wdata != '0 && !cfg_q[SRST_BIT])
        |=> (core_awake && busy && ram_we && ram_addr == '0));

    a_r3_sig_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && ram_addr == '0) |-> (ram_wdata == DW'(SIG)));

    a_r3_id_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && ram_addr == '0 && !host_we) |=> (ram_we && ram_addr == AW'(1) && busy));

    a_r4_join_needs_tx: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(join_net) |-> $past(cfg_q[TXEN_BIT]));

    a_r5_recon_with_join: assert property (@(posedge clk) disable iff (!rst_n)
        join_net |-> my_recon);

    a_r8_zero_sleeps: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_addr == 2'd0 && host_wdata == '0) |=> !core_awake);

    a_r9_soft_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[SRST_BIT] && $past(cfg_q[SRST_BIT])) |-> !core_awake);

endmodule

bind nid_wake_seq nid_wake_seq_chk #(
    .AW       (AW),
    .DW       (DW),
    .SRST_BIT (SRST_BIT),
    .TXEN_BIT (TXEN_BIT),
    .SIG      (SIG)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .cfg_q      (cfg_q),
    .ram_we     (ram_we),
    .ram_addr   (ram_addr),
    .ram_wdata  (ram_wdata),
    .core_awake (core_awake),
    .join_net   (join_net),
    .busy       (busy),
    .my_recon   (my_recon)
);

// File: tb/nid_wake_seq_tb.sv
module nid_wake_seq_tb_top;

    localparam int CLK_P = 10;
    localparam int AW    = 11;
    localparam int DW    = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_we = 1'b0;
    logic [1:0]    host_addr = 2'd0;
    logic [DW-1:0] host_wdata = '0;
    logic          ram_we;
    logic [AW-1:0] ram_addr;
    logic [DW-1:0] ram_wdata;
    logic          core_awake;
    logic          join_net;
    logic          busy;
    logic          my_recon;
    logic [DW-1:0] setup_q;

    int check_cnt = 0;
    int fail_cnt  = 0;
    bit cmp_en    = 1'b0;
    bit done      = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    nid_wake_seq dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .ram_we     (ram_we),
        .ram_addr   (ram_addr),
        .ram_wdata  (ram_wdata),
        .core_awake (core_awake),
        .join_net   (join_net),
        .busy       (busy),
        .my_recon   (my_recon),
        .setup_q    (setup_q)
    );

    // Buffer RAM model: only the two self-test locations are kept
    logic [7:0] ram_m [2];
    always @(posedge clk) begin
        if (ram_we && ram_addr < 2) ram_m[ram_addr[0]] <= ram_wdata;
    end

    // Reference model: 0 sleep, 1 signature, 2 id, 3 waiting, 4 joined
    int         m_state = 0;
    logic [7:0] m_nid   = 0;
    logic [7:0] m_cfg   = 0;
    logic [7:0] m_setup = 0;
    bit         m_recon = 0;

    always @(posedge clk) begin
        int  ns;
        bit  srst;
        bit  nid_w;
        if (!rst_n) begin
            m_state = 0; m_nid = 0; m_cfg = 0; m_setup = 0; m_recon = 0;
        end else begin
            srst  = m_cfg[7];
            nid_w = host_we && host_addr == 2'd0 && !srst;
            ns = m_state;
            if (srst) ns = 0;
            else if (nid_w) ns = (host_wdata != 0) ? 1 : 0;
            else if (m_state == 1) ns = 2;
            else if (m_state == 2) ns = 3;
            else if (m_state == 3 && m_cfg[5]) ns = 4;
            else if (m_state == 4 && !m_cfg[5]) ns = 3;
            if (ns == 0) m_recon = 0;
            else if (m_state == 3 && ns == 4) m_recon = 1;
            if (srst) m_nid = 0;
            else if (nid_w) m_nid = host_wdata;
            if (host_we && host_addr == 2'd1) m_setup = host_wdata;
            if (host_we && host_addr == 2'd2) m_cfg = host_wdata;
            m_state = ns;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        check_cnt++;
        if (!ok) begin
            fail_cnt++;
            $display("FAIL %s %s actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Cycle comparison against the model at every falling edge
    always @(negedge clk) begin
        if (cmp_en && rst_n) begin
            chk(core_awake == (m_state != 0), "R2", "core_awake", core_awake, m_state != 0);
            chk(busy == (m_state == 1 || m_state == 2), "R3", "busy", busy, m_state == 1 || m_state == 2);
            chk(ram_we == (m_state == 1 || m_state == 2), "R3", "ram_we", ram_we, m_state == 1 || m_state == 2);
            if (m_state == 1) begin
                chk(ram_addr == 0, "R3", "ram_addr sig", ram_addr, 0);
                chk(ram_wdata == 8'hD1, "R3", "ram_wdata sig", ram_wdata, 8'hD1);
            end
            if (m_state == 2) begin
                chk(ram_addr == 1, "R3", "ram_addr id", ram_addr, 1);
                chk(ram_wdata == m_nid, "R10", "ram_wdata id", ram_wdata, m_nid);
            end
            chk(join_net == (m_state == 4), "R4", "join_net", join_net, m_state == 4);
            chk(my_recon == m_recon, "R5", "my_recon", my_recon, m_recon);
            chk(setup_q == m_setup, "R7", "setup_q", setup_q, m_setup);
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  %0d/%0d checks passed", check_cnt - fail_cnt, check_cnt);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 20000);
        check_cnt++; fail_cnt++;
        $display("FAIL R1 watchdog actual timeout expected completion");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        cmp_en = 1'b1;
        idle(1);
        // R1 reset state
        chk(!core_awake && !join_net && !busy && !ram_we && !my_recon, "R1", "reset flags",
            {core_awake, join_net, busy, ram_we, my_recon}, 0);

        // R7 setup while asleep
        wr(2'd1, 8'h5A);
        chk(setup_q == 8'h5A, "R7", "setup asleep", setup_q, 8'h5A);

        // R1 zero identifier keeps sleep
        wr(2'd0, 8'h00);
        idle(2);
        chk(!core_awake, "R1", "zero id asleep", core_awake, 0);

        // R2/R3 wake and self-test
        wr(2'd0, 8'h2C);
        chk(core_awake && busy && ram_addr == 0, "R2", "wake cycle1", {core_awake, busy}, 3);
        idle(1);
        chk(ram_addr == 1 && ram_wdata == 8'h2C, "R3", "id cycle", ram_wdata, 8'h2C);
        idle(1);
        chk(ram_m[0] == 8'hD1, "R3", "ram[0]", ram_m[0], 8'hD1);
        chk(ram_m[1] == 8'h2C, "R3", "ram[1]", ram_m[1], 8'h2C);
        chk(!busy, "R3", "busy after", busy, 0);

        // R4 waiting without transmit enable
        idle(5);
        chk(core_awake && !join_net, "R4", "waiting", join_net, 0);
        wr(2'd2, 8'h20);
        chk(!join_net, "R4", "join not yet", join_net, 0);
        idle(1);
        chk(join_net, "R4", "joined", join_net, 1);
        chk(my_recon, "R5", "recon set", my_recon, 1);

        // R6 clearing transmit enable
        wr(2'd2, 8'h00);
        idle(1);
        chk(!join_net && core_awake, "R6", "left network", join_net, 0);
        chk(my_recon, "R5", "recon sticky", my_recon, 1);

        // R10 rewrite while joined
        wr(2'd2, 8'h20);
        idle(2);
        chk(join_net, "R4", "rejoined", join_net, 1);
        wr(2'd0, 8'h77);
        chk(busy && !join_net, "R10", "restart", busy, 1);
        idle(2);
        chk(ram_m[1] == 8'h77, "R10", "ram[1] new id", ram_m[1], 8'h77);

        // R8 zero identifier while awake
        idle(3);
        wr(2'd0, 8'h00);
        chk(!core_awake && !join_net && !my_recon, "R8", "back to sleep",
            {core_awake, join_net, my_recon}, 0);

        // R9 software reset
        wr(2'd0, 8'h11);
        idle(3);
        wr(2'd2, 8'hA0);
        idle(1);
        chk(!core_awake, "R9", "soft reset sleep", core_awake, 0);
        wr(2'd0, 8'h33);
        idle(2);
        chk(!core_awake, "R9", "id ignored", core_awake, 0);
        wr(2'd1, 8'h99);
        chk(setup_q == 8'h99, "R9", "setup during soft reset", setup_q, 8'h99);
        wr(2'd2, 8'h20);
        idle(3);
        chk(!core_awake, "R9", "needs fresh id", core_awake, 0);
        wr(2'd0, 8'h44);
        idle(2);
        chk(ram_m[1] == 8'h44, "R9", "fresh id stored", ram_m[1], 8'h44);
        idle(2);
        chk(join_net, "R4", "joined after soft reset", join_net, 1);

        // R1 hardware reset during self-test
        wr(2'd0, 8'h55);
        @(negedge clk);
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(1);
        chk(!core_awake && !busy && setup_q == 0, "R1", "hard reset", {core_awake, busy}, 0);
        wr(2'd2, 8'h20);
        idle(3);
        chk(!core_awake, "R1", "needs id after reset", core_awake, 0);

        idle(2);
        finish_run();
    end

endmodule